// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous static RAM with registered inputs and a registered read path. Every control, address and write-data input is taken on the rising clock edge. Read data passes through one more register, so it appears one full cycle after the access edge. The word is split into byte lanes of nine bits (eight data bits and one parity bit). Writes come from a global write input, or from a byte-write enable combined with one low-active strobe per lane.

An access starts when an address strobe is seen while the three chip enables select the part. There are two strobes: a processor-side one and a controller-side one. Later cycles run a four-beat burst from an internal two-bit counter, and the advance input steps that counter. When the part is deselected, the last read word is still driven for one extra cycle (double-cycle deselect). A sleep input halts all activity. The default depth is 1024 words. A depth of 64K words is reached with `ADDR_W = 16`.

Top module: `burst_sram`

## Requirements
- R1: While `rstN` is low and after it rises, `dOutEn` is low, no burst is active, and no memory word is changed until the first access.
- R2: An access starts on a rising edge where (`adscN` is low, or `adspN` is low with `ce1N` low) and `ce1N`=0, `ce2`=1, `ce3N`=0 and `sleep`=0. A read accepted at edge k drives the word on `dOut` with `dOutEn` high in the cycle after edge k+1.
- R3: `gwN` low makes the access a write of all 18 bits, whatever `bweN` and `bwN` are.
- R4: With `gwN` high and `bweN` low, `bwN[0]` low writes bits 8:0 and `bwN[1]` low writes bits 17:9; the other lane keeps its contents. With `gwN` high and either `bweN` high or `bwN`=2'b11, the access is a read.
- R5: `adspN` low is ignored while `ce1N` is high. It neither starts nor ends an access, and a running burst carries on at its counter address instead of `addrIn`.
- R6: A strobe accepted while the enables do not select the part ends the burst. Later cycles make no access until the next selected strobe.
- R7: With no strobe and `advN` low, the burst counter steps. Address bits 1:0 become (start bits 1:0) XOR count by default, or (start + count) mod 4 with `LINEAR`=1. The upper bits stay fixed and the count wraps after four beats. With `advN` high the same address is accessed again.
- R8: A write cycle inside a burst stores `dIn`, taken on that edge, at the burst counter address.
- R9: If a read was accepted on the edge just before a deselect edge, its data is driven for one extra cycle with `dOut` held, and `dOutEn` then falls.
- R10: After any write access, `dOutEn` stays low through continuation read cycles until a read is started by an address strobe.
- R11: `dOutEn` is low whenever `oeN` is high, and low during a cycle whose inputs make a write access. Both gates act without a clock edge.
- R12: While `sleep` is high, no access or write takes place and `dOutEn` is low. The burst ends, and after `sleep` falls `dOutEn` stays low until a strobe-started read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous low-active reset of the control state |
| addrIn | input | ADDR_W | Word address, taken on a starting edge |
| adspN | input | 1 | Processor-side address strobe, low active, gated by `ce1N` |
| adscN | input | 1 | Controller-side address strobe, low active |
| advN | input | 1 | Burst advance, low active |
| ce1N | input | 1 | Chip enable, low active |
| ce2 | input | 1 | Chip enable, high active |
| ce3N | input | 1 | Chip enable, low active |
| gwN | input | 1 | Global write of all lanes, low active |
| bweN | input | 1 | Byte-write enable, low active |
| bwN | input | LANES | Per-lane write strobes, low active, bit 0 = bits 8:0 |
| oeN | input | 1 | Asynchronous output enable, low active |
| sleep | input | 1 | Sleep request, high active |
| dIn | input | LANE_W*LANES | Write data |
| dOut | output | LANE_W*LANES | Registered read data |
| dOutEn | output | 1 | Output drive enable for the data pad |

## Verification
Two functions can fall in the same cycle: a read still in the output register, and a write or deselect on the next edge. The bench provokes the first by issuing a continuation write to a word whose read was accepted one edge earlier. The reference model must return the pre-write value and drop `dOutEn` during the write cycle. The second case is a read followed at once by a deselecting strobe, which must hold the same word for one extra cycle. The bench drives both cases and compares them against the model on every clock.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Strobes passed from control to datapath for one clock edge.
  typedef struct packed {
    logic rdIssue;    // read accepted this edge
    logic wrIssue;    // write accepted this edge
    logic deselHold;  // deselect directly behind a read
    logic flush;      // sleep: clear the read pipeline
  } sramCtl_t;

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int LINEAR = 0
) (
  input  logic [1:0] startLo,
  input  logic [1:0] beat,
  output logic [1:0] addrLo
);

  generate
    if (LINEAR != 0) begin : gLinear
      assign addrLo = startLo + beat;
    end else begin : gInterleave
      assign addrLo = startLo ^ beat;
    end
  endgenerate

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LINEAR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              sleep,
  output sramCtl_t          ctl,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LANES-1:0]  laneWe
);

  localparam int HI_W = ADDR_W - 2;

  logic              activeQ;
  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        cntQ;
  logic              quietQ;
  logic              lastReadQ;

  logic              selected, strobe, startSel, deselNow, contNow, access;
  logic              isWrite, quietEff;
  logic [1:0]        nextCnt, burstLo;
  logic [ADDR_W-1:0] baseNext;
  logic [LANES-1:0]  laneReq;

  // chip select and strobe qualification
  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    strobe   = !sleep && ((!adspN && !ce1N) || !adscN);
    startSel = strobe && selected;
    deselNow = strobe && !selected;
    contNow  = !strobe && activeQ && !sleep;
    access   = startSel || contNow;
  end

  // burst counter and effective address
  always_comb begin
    if (startSel)   nextCnt = 2'd0;
    else if (!advN) nextCnt = cntQ + 2'd1;
    else            nextCnt = cntQ;
    baseNext = startSel ? addrIn : baseQ;
  end

  sram_burst_seq #(.LINEAR(LINEAR)) u_seq (
    .startLo (baseNext[1:0]),
    .beat    (nextCnt),
    .addrLo  (burstLo)
  );

  assign effAddr = {baseNext[ADDR_W-1 -: HI_W], burstLo};

  // per-lane write decode
  generate
    for (genvar g = 0; g < LANES; g++) begin : gLaneDec
      assign laneReq[g] = !gwN || (!bweN && !bwN[g]);
    end
  endgenerate

  always_comb begin
    isWrite       = |laneReq;
    quietEff      = startSel ? 1'b0 : quietQ;
    ctl.wrIssue   = access && isWrite;
    ctl.rdIssue   = access && !isWrite && !quietEff;
    ctl.deselHold = deselNow && lastReadQ;
    ctl.flush     = sleep;
    laneWe        = ctl.wrIssue ? laneReq : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      baseQ     <= '0;
      cntQ      <= 2'd0;
      quietQ    <= 1'b0;
      lastReadQ <= 1'b0;
    end else begin
      lastReadQ <= ctl.rdIssue;
      if (sleep)         activeQ <= 1'b0;
      else if (startSel) activeQ <= 1'b1;
      else if (deselNow) activeQ <= 1'b0;
      if (startSel) baseQ <= addrIn;
      if (access)   cntQ  <= nextCnt;
      if (sleep || ctl.wrIssue) quietQ <= 1'b1;
      else if (startSel)        quietQ <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sramCtl_t                ctl,
  input  logic [ADDR_W-1:0]       effAddr,
  input  logic [LANES-1:0]        laneWe,
  input  logic [LANE_W*LANES-1:0] dIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANE_W*LANES-1:0] dOut,
  output logic                    dOutEn,
  output logic                    rdBusy
);

  localparam int DATA_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdPendQ, holdQ, validQ;
  logic [DATA_W-1:0] dataQ, rdWord;

  // one storage array per byte lane
  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      logic [LANE_W-1:0] laneMem [DEPTH];
      always_ff @(posedge clk) begin
        if (laneWe[g]) laneMem[effAddr] <= dIn[g*LANE_W +: LANE_W];
      end
      assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddrQ];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      rdAddrQ <= '0;
      holdQ   <= 1'b0;
      validQ  <= 1'b0;
      dataQ   <= '0;
    end else if (ctl.flush) begin
      rdPendQ <= 1'b0;
      holdQ   <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      rdPendQ <= ctl.rdIssue;
      holdQ   <= ctl.deselHold;
      if (ctl.rdIssue) rdAddrQ <= effAddr;
      if (rdPendQ) begin
        dataQ  <= rdWord;
        validQ <= 1'b1;
      end else begin
        validQ <= holdQ;
      end
    end
  end

  assign dOut   = dataQ;
  assign dOutEn = validQ && !oeN && !sleep && !ctl.wrIssue;
  assign rdBusy = rdPendQ;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int LINEAR = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    oeN,
  input  logic                    sleep,
  input  logic [LANE_W*LANES-1:0] dIn,
  output logic [LANE_W*LANES-1:0] dOut,
  output logic                    dOutEn
);

  localparam int DATA_W = LANE_W * LANES;

  sramCtl_t          ctlBus;
  logic [ADDR_W-1:0] effAddr;
  logic [LANES-1:0]  laneWe;
  logic              rdBusy;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LINEAR(LINEAR)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .sleep(sleep),
    .ctl(ctlBus), .effAddr(effAddr), .laneWe(laneWe)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .effAddr(effAddr), .laneWe(laneWe),
    .dIn(dIn), .oeN(oeN), .sleep(sleep),
    .dOut(dOut), .dOutEn(dOutEn), .rdBusy(rdBusy)
  );

endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              dOutEn,
  input logic [DATA_W-1:0] dOut,
  input logic              wrNow,
  input logic              holdFlag,
  input logic              rdBusy
);

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !dOutEn);

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrNow |=> ##1 !dOutEn);

  // R9
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdFlag |=> ##1 $stable(dOut));

  // R2
  data_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rdBusy) |-> $stable(dOut));

endmodule

bind burst_sram sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .dOutEn(dOutEn), .dOut(dOut),
  .wrNow(ctlBus.wrIssue), .holdFlag(ctlBus.deselHold), .rdBusy(rdBusy)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  addrIn;
  logic        adspN, adscN, advN, ce1N, ce2, ce3N, gwN, bweN, oeN, sleep;
  logic [1:0]  bwN;
  logic [17:0] dIn;
  logic [17:0] dOut;
  logic        dOutEn;

  int    testCnt = 0;
  int    failCnt = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference model state
  logic [17:0] mMem [int];
  int          mActive, mBase, mCnt, mQuiet, mRdPend, mRdAddr, mHold, mValid;
  logic [17:0] mData;
  bit          mKnown;

  always #5 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .sleep(sleep), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic setIdle();
    adspN = 1; adscN = 1; advN = 1; ce1N = 0; ce2 = 1; ce3N = 0;
    gwN = 1; bweN = 1; bwN = 2'b11; oeN = 0;
  endtask

  // one cycle: compare, then advance the model across the rising edge
  task automatic tick();
    bit sel, strb, stSel, dsl, acc, wr, laneA, laneB, expEn, oldPend;
    int ncnt, nbase, addr;
    logic [17:0] w;
    #1;
    sel   = !ce1N && ce2 && !ce3N;
    strb  = !sleep && ((!adspN && !ce1N) || !adscN);
    stSel = strb && sel;
    dsl   = strb && !sel;
    acc   = stSel || (!strb && mActive != 0 && !sleep);
    laneA = !gwN || (!bweN && !bwN[0]);
    laneB = !gwN || (!bweN && !bwN[1]);
    wr    = laneA || laneB;
    ncnt  = stSel ? 0 : (advN ? mCnt : (mCnt + 1) % 4);
    nbase = stSel ? int'(addrIn) : mBase;
    addr  = (nbase & ~3) | ((nbase & 3) ^ ncnt);
    expEn = (mValid != 0) && !oeN && !sleep && !(acc && wr);
    chk(curReq, "dOutEn", {31'd0, dOutEn}, {31'd0, expEn});
    if (expEn && mKnown) chk(curReq, "dOut", {14'd0, dOut}, {14'd0, mData});
    @(posedge clk);
    if (!rstN) begin
      mActive = 0; mBase = 0; mCnt = 0; mQuiet = 0;
      mRdPend = 0; mHold = 0; mValid = 0;
    end else if (sleep) begin
      mRdPend = 0; mHold = 0; mValid = 0; mActive = 0; mQuiet = 1;
    end else begin
      oldPend = (mRdPend != 0);
      if (oldPend) begin
        mKnown = mMem.exists(mRdAddr);
        if (mKnown) mData = mMem[mRdAddr];
        mValid = 1;
      end else begin
        mValid = mHold;
      end
      mHold = (dsl && oldPend) ? 1 : 0;
      if (acc && wr) begin
        w = mMem.exists(addr) ? mMem[addr] : 18'd0;
        if (laneA) w[8:0]  = dIn[8:0];
        if (laneB) w[17:9] = dIn[17:9];
        mMem[addr] = w;
      end
      mRdPend = (acc && !wr && !(stSel ? 0 : mQuiet != 0)) ? 1 : 0;
      mRdAddr = addr;
      if (acc && wr) mQuiet = 1;
      else if (stSel) mQuiet = 0;
      if (stSel) mActive = 1;
      else if (dsl) mActive = 0;
      if (stSel) mBase = int'(addrIn);
      if (acc) mCnt = ncnt;
    end
    @(negedge clk);
  endtask

  task automatic wrWord(int a, logic [17:0] d);
    adscN = 0; addrIn = 10'(a); gwN = 0; dIn = d;
    tick();
    setIdle();
  endtask

  task automatic rdStart(int a, bit useP);
    if (useP) adspN = 0; else adscN = 0;
    addrIn = 10'(a);
    tick();
    setIdle();
  endtask

  initial begin
    setIdle();
    rstN = 0; sleep = 0; addrIn = '0; dIn = '0;
    @(negedge clk);
    curReq = "R1";
    repeat (3) tick();
    chk("R1", "dOutEn in reset", {31'd0, dOutEn}, 32'd0);
    rstN = 1;
    repeat (2) tick();
    chk("R1", "dOutEn after reset", {31'd0, dOutEn}, 32'd0);

    curReq = "R3";
    for (int i = 0; i < 24; i++) wrWord(i, 18'(32'h1_0000 + i * 32'h1357));
    wrWord(5, 18'h2A5A5);

    curReq = "R2";
    rdStart(5, 0); repeat (3) tick();
    rdStart(3, 1); repeat (2) tick();

    curReq = "R4";
    adscN = 0; addrIn = 10'd5; bweN = 0; bwN = 2'b10; dIn = 18'h3FFFF; tick(); setIdle();
    rdStart(5, 0); repeat (2) tick();
    adscN = 0; addrIn = 10'd5; bweN = 0; bwN = 2'b01; dIn = 18'h00000; tick(); setIdle();
    rdStart(5, 0); repeat (2) tick();
    adscN = 0; addrIn = 10'd5; bweN = 1; bwN = 2'b00; dIn = 18'h12345; tick(); setIdle();
    repeat (2) tick();
    adscN = 0; addrIn = 10'd6; bweN = 0; bwN = 2'b11; dIn = 18'h12345; tick(); setIdle();
    repeat (2) tick();

    curReq = "R8";
    adscN = 0; addrIn = 10'd9; gwN = 0; dIn = 18'h0AAA1; tick();
    adscN = 1; advN = 0; dIn = 18'h0BBB2; tick();
    dIn = 18'h0CCC3; tick();
    dIn = 18'h0DDD4; tick();
    advN = 1; dIn = 18'h0EEE5; tick();
    setIdle();

    curReq = "R7";
    rdStart(9, 0);
    advN = 0; repeat (5) tick();
    advN = 1; repeat (2) tick();

    curReq = "R5";
    rdStart(13, 0); tick();
    adspN = 0; ce1N = 1; addrIn = 10'd2; advN = 0; repeat (3) tick();
    setIdle(); repeat (2) tick();

    curReq = "R9";
    rdStart(5, 0);
    adscN = 0; ce2 = 0; tick(); setIdle(); repeat (3) tick();
    curReq = "R6";
    rdStart(7, 0); tick();
    adspN = 0; ce3N = 1; tick(); setIdle(); repeat (4) tick();

    curReq = "R10";
    wrWord(20, 18'h15A5A); repeat (3) tick();
    advN = 0; repeat (2) tick(); setIdle();
    rdStart(20, 1); repeat (2) tick();

    curReq = "R11";
    rdStart(5, 0); tick();
    oeN = 1; tick(); oeN = 0; tick();
    gwN = 0; dIn = 18'h0F0F0; tick(); setIdle();
    rdStart(5, 0); repeat (2) tick();

    curReq = "R12";
    adscN = 0; ce2 = 0; tick(); setIdle(); repeat (3) tick();
    sleep = 1; adscN = 0; gwN = 0; addrIn = 10'd5; dIn = 18'h33333; repeat (3) tick();
    setIdle(); sleep = 0; repeat (3) tick();
    rdStart(5, 0); repeat (2) tick();
    chk("R12", "dOutEn after wake read", {31'd0, dOutEn}, 32'd1);
    chk("R12", "word kept over sleep", {14'd0, dOut}, {14'd0, 18'h0F0F0});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog %s actual=hung expected=done", curReq);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule